// File: doc/BRIEF.md
# Video Timing Extractor

This block recovers line and field timing from a 10-bit parallel video word stream clocked at the pixel rate. It drives three timing outputs: horizontal blanking, vertical blanking and field. The data word is passed through at the same time, delayed so that the timing outputs stay aligned with it. A mode input picks where the timing comes from. With the mode low, the block follows horizontal, vertical and field strobes supplied from outside. With the mode high, it searches the data for embedded timing reference sequences and decodes them into the three outputs.

A timing reference sequence is four words: 3FFh, then 000h twice, then a flag word. In the flag word, bit 8 carries the field, bit 7 carries vertical blanking and bit 6 marks the word. Bit 6 high means end of active video, and bit 6 low means start of active video. A configuration bit chooses how the horizontal output is shaped from these words. In line shape, the output covers all of horizontal blanking, including both reference sequences. In flag shape, the output follows the bit 6 flag carried in each sequence.

Top module: `video_timing_extract`

## Requirements
- R1: `dout` in any cycle equals `din` from four cycles earlier. The four-word pipeline latency is cleared to zero by reset.
- R2: A synchronous reset drives `dout`, `h_out`, `v_out` and `f_out` low. It also returns the shape setting to line shape (0), so line shaping applies until a write occurs.
- R3: A sequence is recognised only when the words 3FFh, 000h, 000h and a flag word arrive in consecutive cycles. The decoded field comes from bit 8, vertical blanking from bit 7, and the end/start marker from bit 6 (1 = end of active video).
- R4: If 3FFh is not followed by two 000h words, the block changes neither `h_out`, `v_out` nor `f_out`.
- R5: In embedded mode, `v_out` and `f_out` take the flags of each recognised sequence. They change in the cycle when that sequence's 3FFh word appears on `dout`, and they hold between sequences.
- R6: In line shape (setting 0), `h_out` rises with the 3FFh word of an end-of-active sequence on `dout`. It stays high through the whole following start-of-active sequence and falls with the first word after that sequence's flag word.
- R7: In flag shape (setting 1), `h_out` takes bit 6 of each recognised sequence. It changes in the cycle when that sequence's 3FFh appears on `dout`.
- R8: With `trs_mode` low, `h_out`, `v_out` and `f_out` equal `ext_h`, `ext_v` and `ext_f` from four cycles earlier. The shape setting has no effect in this mode.
- R9: The shape setting loads `cfg_h_flag` on a cycle with `cfg_we` high. When `cfg_we` is low, `cfg_h_flag` is ignored.
- R10: Sequence tracking continues while `trs_mode` is low. After `trs_mode` returns high, the outputs show the decoded state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Parallel video word |
| trs_mode | input | 1 | 1 = timing from embedded sequences, 0 = timing from external strobes |
| cfg_we | input | 1 | Write enable for the shape setting |
| cfg_h_flag | input | 1 | Shape value to load: 0 = line shape, 1 = flag shape |
| ext_h | input | 1 | External horizontal blanking strobe |
| ext_v | input | 1 | External vertical blanking strobe |
| ext_f | input | 1 | External field strobe |
| dout | output | 10 | Video word delayed by four cycles |
| h_out | output | 1 | Horizontal blanking, aligned with `dout` |
| v_out | output | 1 | Vertical blanking, aligned with `dout` |
| f_out | output | 1 | Field, aligned with `dout` |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and known once reset is released.
- Two reference sequences never overlap, so a start-of-active sequence is never cut short by a new 3FFh within four words.

The stimulus holds to these conditions in three ways:
- Payload words are drawn only from 004h to 3FBh, so they can neither form nor mimic a sequence.
- Every generated line separates its two sequences with blanking words, and follows them with at least six active words.
- Broken sequences (3FFh followed by one 000h or by none) are placed deliberately inside blanking, with mode and shape changes scattered across the stream.

// File: rtl/vte_pkg.sv
package vte_pkg;

  // words in one timing reference sequence (fixed by the video format)
  localparam int TRS_WORDS = 4;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vte_flags_t;

  typedef enum logic {
    HSHAPE_LINE = 1'b0,
    HSHAPE_FLAG = 1'b1
  } hshape_e;

  // output level of horizontal blanking right after a sequence
  function automatic logic blank_level(input hshape_e s, input logic hflag);
    return (s == HSHAPE_FLAG) ? hflag : 1'b1;
  endfunction

  // cycles the line shape keeps H high after a start-of-active sequence
  function automatic int unsigned sav_hold(input hshape_e s, input logic hflag);
    return (s == HSHAPE_LINE && !hflag) ? TRS_WORDS : 0;
  endfunction

endpackage

// File: rtl/vte_delay.sv
module vte_delay #(
  parameter int W      = 10,
  parameter int STAGES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [W-1:0]                 d,
  output logic [STAGES-1:0][W-1:0]     taps
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else begin
      taps[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        taps[s] <= taps[s-1];
      end
    end
  end

endmodule

// File: rtl/vte_trs_match.sv
module vte_trs_match
  import vte_pkg::*;
#(
  parameter int DW   = 10,
  parameter int NTAP = TRS_WORDS - 1
) (
  input  logic [DW-1:0]              din,
  input  logic [NTAP-1:0][DW-1:0]    taps,
  output logic                       hit,
  output vte_flags_t                 fl
);

  localparam int NZERO = NTAP - 1;
  localparam int FBIT  = DW - 2;
  localparam int VBIT  = DW - 3;
  localparam int HBIT  = DW - 4;

  function automatic logic all_ones(input logic [DW-1:0] w);
    return &w;
  endfunction

  logic [NZERO-1:0] zero_ok;
  logic             lead_ok;

  generate
    for (genvar z = 0; z < NZERO; z++) begin : g_zero
      assign zero_ok[z] = (taps[z] == '0);
    end
  endgenerate

  assign lead_ok = all_ones(taps[NTAP-1]);
  assign hit     = lead_ok && (&zero_ok);

  assign fl.f = din[FBIT];
  assign fl.v = din[VBIT];
  assign fl.h = din[HBIT];

endmodule

// File: rtl/vte_track.sv
module vte_track
  import vte_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  vte_flags_t fl,
  input  hshape_e    shape,
  output vte_flags_t cur,
  output vte_flags_t nxt
);

  localparam int CW = $clog2(TRS_WORDS + 1);

  logic [CW-1:0] hold_q;
  logic [CW-1:0] hold_d;
  logic          fall_now;

  assign fall_now = (hold_q == CW'(1));

  always_comb begin
    nxt    = cur;
    hold_d = (hold_q != '0) ? hold_q - CW'(1) : '0;
    if (fall_now) begin
      nxt.h = 1'b0;
    end
    if (hit) begin
      nxt.v  = fl.v;
      nxt.f  = fl.f;
      nxt.h  = blank_level(shape, fl.h);
      hold_d = CW'(sav_hold(shape, fl.h));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      hold_q <= '0;
    end else begin
      cur    <= nxt;
      hold_q <= hold_d;
    end
  end

  // R6
  h_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cur.h) |-> ($past(hold_q) == CW'(1) || $past(hit && !fl.h)));

  // R5
  vf_capture_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cur.v == $past(fl.v) && cur.f == $past(fl.f)));

endmodule

// File: rtl/video_timing_extract.sv
module video_timing_extract
  import vte_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          trs_mode,
  input  logic          cfg_we,
  input  logic          cfg_h_flag,
  input  logic          ext_h,
  input  logic          ext_v,
  input  logic          ext_f,
  output logic [DW-1:0] dout,
  output logic          h_out,
  output logic          v_out,
  output logic          f_out
);

  localparam int XDLY = TRS_WORDS - 1;

  // data pipeline, also the history window of the sequence matcher
  logic [TRS_WORDS-1:0][DW-1:0] dtap;

  vte_delay #(.W(DW), .STAGES(TRS_WORDS)) u_data (
    .clk  (clk),
    .rst  (rst),
    .d    (din),
    .taps (dtap)
  );

  assign dout = dtap[TRS_WORDS-1];

  logic       trs_hit;
  vte_flags_t trs_fl;

  vte_trs_match #(.DW(DW), .NTAP(TRS_WORDS - 1)) u_match (
    .din  (din),
    .taps (dtap[TRS_WORDS-2:0]),
    .hit  (trs_hit),
    .fl   (trs_fl)
  );

  // shape configuration
  hshape_e shape_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shape_q <= HSHAPE_LINE;
    end else if (cfg_we) begin
      shape_q <= hshape_e'(cfg_h_flag);
    end
  end

  vte_flags_t trk_cur;
  vte_flags_t trk_nxt;

  vte_track u_track (
    .clk   (clk),
    .rst   (rst),
    .hit   (trs_hit),
    .fl    (trs_fl),
    .shape (shape_q),
    .cur   (trk_cur),
    .nxt   (trk_nxt)
  );

  // external strobe pipeline (last stage is the output register)
  vte_flags_t ext_pipe [XDLY];
  vte_flags_t ext_in;

  assign ext_in = '{f: ext_f, v: ext_v, h: ext_h};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < XDLY; s++) begin
        ext_pipe[s] <= '0;
      end
    end else begin
      ext_pipe[0] <= ext_in;
      for (int s = 1; s < XDLY; s++) begin
        ext_pipe[s] <= ext_pipe[s-1];
      end
    end
  end

  vte_flags_t out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      out_q <= trs_mode ? trk_nxt : ext_pipe[XDLY-1];
    end
  end

  assign h_out = out_q.h;
  assign v_out = out_q.v;
  assign f_out = out_q.f;

  // cycles since reset, for checks that look back over the pipeline
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q <= '0;
    end else if (warm_q != 3'd7) begin
      warm_q <= warm_q + 3'd1;
    end
  end

  assign warm = (warm_q >= 3'd4);

  // R1
  data_align_chk: assert property (@(posedge clk) disable iff (rst)
    warm |-> (dout == $past(din, 4)));

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && !trs_mode) |=> (h_out == $past(ext_h, 4) && v_out == $past(ext_v, 4)
                             && f_out == $past(ext_f, 4)));

  // R6
  eav_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (trs_mode && trs_hit && trs_fl.h) |=> h_out);

  // R7
  flag_sav_chk: assert property (@(posedge clk) disable iff (rst)
    (trs_mode && trs_hit && !trs_fl.h && shape_q == HSHAPE_FLAG) |=> !h_out);

  // R10
  trs_out_match_chk: assert property (@(posedge clk) disable iff (rst)
    trs_mode |=> (out_q == trk_cur));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(shape_q));

endmodule

// File: tb/test_video_timing_extract.sv
module test_video_timing_extract;

  localparam int NMAX = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] din = '0;
  logic       trs_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_h_flag = 1'b0;
  logic       ext_h = 1'b0;
  logic       ext_v = 1'b0;
  logic       ext_f = 1'b0;
  logic [9:0] dout;
  logic       h_out;
  logic       v_out;
  logic       f_out;

  video_timing_extract i_video_timing_extract (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .trs_mode   (trs_mode),
    .cfg_we     (cfg_we),
    .cfg_h_flag (cfg_h_flag),
    .ext_h      (ext_h),
    .ext_v      (ext_v),
    .ext_f      (ext_f),
    .dout       (dout),
    .h_out      (h_out),
    .v_out      (v_out),
    .f_out      (f_out)
  );

  always #10 clk = ~clk;

  // stimulus per cycle
  logic [9:0] s_din [NMAX];
  bit s_mode [NMAX];
  bit s_we   [NMAX];
  bit s_val  [NMAX];
  bit s_eh   [NMAX];
  bit s_ev   [NMAX];
  bit s_ef   [NMAX];
  bit s_part [NMAX];
  // expected per cycle
  logic [9:0] x_dout [NMAX];
  bit x_h   [NMAX];
  bit x_v   [NMAX];
  bit x_f   [NMAX];
  bit x_sel [NMAX];
  bit x_trs [NMAX];
  bit x_wr  [NMAX];

  int n = 0;
  bit g_mode = 1'b1;
  bit g_we = 1'b0;
  bit g_val = 1'b0;
  bit g_mix = 1'b0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int unsigned seed_init;

  task automatic push(input logic [9:0] w, input bit part);
    if (n < NMAX) begin
      if (g_mix && ($urandom % 40) == 0) g_mode = ~g_mode;
      s_din[n]  = w;
      s_mode[n] = g_mode;
      s_we[n]   = g_we;
      s_val[n]  = g_we ? g_val : 1'($urandom);
      s_eh[n]   = 1'($urandom);
      s_ev[n]   = 1'($urandom);
      s_ef[n]   = 1'($urandom);
      s_part[n] = part;
      g_we = 1'b0;
      n++;
    end
  endtask

  function automatic logic [9:0] rword();
    return 10'(4 + ($urandom % 1016));
  endfunction

  task automatic set_cfg(input bit v);
    g_we  = 1'b1;
    g_val = v;
  endtask

  task automatic push_trs(input bit hf);
    bit f = 1'($urandom);
    bit v = 1'($urandom);
    logic [5:0] low = 6'($urandom % 63);
    push(10'h3FF, 1'b0);
    push(10'h000, 1'b0);
    push(10'h000, 1'b0);
    push({1'b1, f, v, hf, low}, 1'b0);
  endtask

  task automatic push_line();
    int nb = 2 + int'($urandom % 7);
    int na = 6 + int'($urandom % 15);
    push_trs(1'b1);
    for (int k = 0; k < nb; k++) begin
      if (($urandom % 4) == 0) begin
        push(10'h3FF, 1'b0);
        if (($urandom % 2) == 0) push(10'h000, 1'b0);
        push(rword(), 1'b1);
      end
      push(rword(), 1'b0);
    end
    push_trs(1'b0);
    for (int k = 0; k < na; k++) push(rword(), 1'b0);
  endtask

  // expected values from the requirements
  task automatic compute();
    bit sel = 1'b0;
    bit wr = 1'b0;
    bit th = 1'b0, tv = 1'b0, tf = 1'b0;
    int fall_at = -1;
    for (int i = 0; i < n; i++) begin
      bit trs;
      x_sel[i] = sel;
      x_wr[i]  = wr;
      trs = (i >= 3) && s_din[i-3] == 10'h3FF && s_din[i-2] == 10'h000
            && s_din[i-1] == 10'h000;
      x_trs[i] = trs;
      if (trs) begin
        tv = s_din[i][7];
        tf = s_din[i][8];
        if (sel) begin
          th = s_din[i][6];
          fall_at = -1;
        end else begin
          th = 1'b1;
          fall_at = s_din[i][6] ? -1 : i + 4;
        end
      end else if (fall_at == i) begin
        th = 1'b0;
        fall_at = -1;
      end
      x_dout[i] = (i >= 3) ? s_din[i-3] : 10'h000;
      if (s_mode[i]) begin
        x_h[i] = th; x_v[i] = tv; x_f[i] = tf;
      end else begin
        x_h[i] = (i >= 3) ? s_eh[i-3] : 1'b0;
        x_v[i] = (i >= 3) ? s_ev[i-3] : 1'b0;
        x_f[i] = (i >= 3) ? s_ef[i-3] : 1'b0;
      end
      if (s_we[i]) begin
        sel = s_val[i];
        wr  = 1'b1;
      end
    end
  endtask

  function automatic string htag(input int i);
    if (!s_mode[i]) return "R8";
    if (i > 0 && !s_mode[i-1]) return "R10";
    if (s_part[i]) return "R4";
    if (!x_wr[i]) return "R2";
    if (i > 0 && !s_we[i-1] && s_val[i-1] != x_sel[i]) return "R9";
    return x_sel[i] ? "R7" : "R6";
  endfunction

  function automatic string vtag(input int i);
    if (!s_mode[i]) return "R8";
    if (x_trs[i]) return "R3";
    if (s_part[i]) return "R4";
    return "R5";
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_at(input int i);
    cmp("R1", "dout", int'(dout), int'(x_dout[i]));
    cmp(htag(i), "h_out", int'(h_out), int'(x_h[i]));
    cmp(vtag(i), "v_out", int'(v_out), int'(x_v[i]));
    cmp(vtag(i), "f_out", int'(f_out), int'(x_f[i]));
  endtask

  task automatic drive(input int i);
    din        = s_din[i];
    trs_mode   = s_mode[i];
    cfg_we     = s_we[i];
    cfg_h_flag = s_val[i];
    ext_h      = s_eh[i];
    ext_v      = s_ev[i];
    ext_f      = s_ef[i];
  endtask

  initial begin
    seed_init = $urandom(32'd7731);
    // default line shape, no configuration writes yet
    g_mode = 1'b1;
    for (int k = 0; k < 6; k++) push(rword(), 1'b0);
    for (int k = 0; k < 3; k++) push_line();
    // doubled 3FFh ahead of a sequence (R3 corner)
    push(10'h3FF, 1'b0);
    push_line();
    // flag shape
    set_cfg(1'b1);
    push(rword(), 1'b0);
    for (int k = 0; k < 3; k++) push_line();
    // external strobes, shape writes have no effect
    g_mode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      set_cfg(1'($urandom));
      push_line();
    end
    // back to embedded mode, line shape
    g_mode = 1'b1;
    set_cfg(1'b0);
    for (int k = 0; k < 3; k++) push_line();
    // random mix of mode and shape changes
    g_mix = 1'b1;
    for (int k = 0; k < 35; k++) begin
      if (($urandom % 3) == 0) set_cfg(1'($urandom));
      push_line();
    end
    g_mix = 1'b0;
    for (int k = 0; k < 8; k++) push(rword(), 1'b0);
    compute();

    // reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R2", "dout", int'(dout), 0);
    cmp("R2", "h_out", int'(h_out), 0);
    cmp("R2", "v_out", int'(v_out), 0);
    cmp("R2", "f_out", int'(f_out), 0);

    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check_at(i - 1);
      drive(i);
      rst = 1'b0;
    end
    @(negedge clk);
    check_at(n - 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule